// File: doc/BRIEF.md
# Accumulator Processor with Polled Interrupt Service

This block is a compact accumulator machine with 4-bit data and an 8-bit address space. It holds a program counter, an accumulator, a data register and a zero flag. It fetches instructions and data from one external memory, which it reads combinationally and writes in one clock. Eight operations are defined: loading, storing, copying, subtracting, masking, a conditional branch, a no-op and a return from service. Each operation is one nibble. Operations that name an address are followed by two address nibbles.

Several external request lines are watched between instructions. When a request is accepted, the processor saves its program counter and zero flag in shadow registers and masks further requests. A built-in service sequence then polls the lines in a fixed priority and acknowledges the winner. It performs that source's memory-mapped transfer between memory, the input nibbles and the output register. It then continues at a fixed handler address, where program code ends with the return operation.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_addr is 0x00, mem_we is 0, irq_ack is all zero and op0 is 0. Reset clears PC, AC, DR and Z and masks interrupts.
- R2: Opcodes are NOP=0, LOAD=1, STORE=2, MOVE=3, SUB=4, AND=5, JUMPZ=6 and RETINT=7; codes 8 to 15 act as NOP. LOAD, STORE and JUMPZ are followed by the high and then the low address nibble, and PC steps past all three words.
- R3: LOAD puts memory[addr] in AC, STORE writes AC to memory[addr], MOVE copies AC into DR, and NOP changes nothing.
- R4: SUB leaves (AC - DR) mod 16 in AC and AND leaves AC & DR in AC. After LOAD, SUB or AND, Z is 1 exactly when the new AC is 0.
- R5: JUMPZ loads PC with its address when Z is 1 and otherwise falls through to the next instruction.
- R6: A request is taken only at an instruction boundary with interrupts enabled. After reset the shadow PC is 0x01 and the shadow Z is 0, so a RETINT at 0x00 enables interrupts and continues at 0x01. Requests are ignored while interrupts are masked.
- R7: On entry PC and Z are saved and interrupts are masked. After the transfer, execution continues at HANDLER_ADDR (0xE0). RETINT restores the saved PC and Z and unmasks interrupts.
- R8: Request bit 0 (A) has the highest priority, then bit 1 (B), bit 2 (C) and bit 3 (D). One request is serviced per entry, and it is acknowledged by a single-cycle pulse on its irq_ack bit.
- R9: Source A copies memory[0xF4] to op0.
- R10: Source B writes ip0 to memory[0xF5].
- R11: Source C copies memory[{0xF, ip1}] to op0.
- R12: With NUM_IRQ=4, source D copies memory[{ip2, ip3}] (ip2 is the high nibble) to op0.
- R13: op0 keeps its value until source A, C or D writes it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address |
| mem_rdata | input | 4 | Memory read data, combinational from mem_addr |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| irq_req | input | 4 | Level-sensitive requests, bit 0 is A |
| irq_ack | output | 4 | One-cycle acknowledge, one bit per request |
| ip0 | input | 4 | Input nibble for source B |
| ip1 | input | 4 | Low address nibble for source C |
| ip2 | input | 4 | High address nibble for source D |
| ip3 | input | 4 | Low address nibble for source D |
| op0 | output | 4 | Registered output nibble |

## Verification
The bench builds the block with its default parameters: 4-bit data, 8-bit addresses, four request lines and a handler at 0xE0. This build includes the optional fourth source and the full priority chain. The 4-bit data width makes subtraction wrap-around and all-zero masks easy to reach with small operands. A two-nibble address reaches the whole memory, so the bench can place the programs, the handler and the service locations anywhere. The four-line build also lets two simultaneous requests, one high and one low in priority, show the ordering and the return to the interrupted program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP    = 4'd0,
      OPC_LOAD   = 4'd1,
      OPC_STORE  = 4'd2,
      OPC_MOVE   = 4'd3,
      OPC_SUB    = 4'd4,
      OPC_AND    = 4'd5,
      OPC_JUMPZ  = 4'd6,
      OPC_RETINT = 4'd7
   } opcode_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_ADRH,
      ST_ADRL,
      ST_EXEC,
      ST_POLL,
      ST_SERVE
   } state_e;

   typedef enum logic [1:0] {
      ALU_HOLD,
      ALU_LOAD,
      ALU_SUB,
      ALU_AND
   } alu_op_e;

   function automatic logic takes_addr(input logic [OPC_W-1:0] opc);
      return (opc == OPC_LOAD) || (opc == OPC_STORE) || (opc == OPC_JUMPZ);
   endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  alu_op_e       op,
   input  logic          mv,
   input  logic [DW-1:0] operand,
   input  logic          z_ld,
   input  logic          z_val,
   output logic [DW-1:0] acc,
   output logic [DW-1:0] dr,
   output logic          z
);

   logic [DW-1:0] acc_nx;
   logic          upd;

   always_comb begin
      upd    = 1'b1;
      acc_nx = acc;
      case (op)
         ALU_LOAD: acc_nx = operand;
         ALU_SUB:  acc_nx = acc - dr;
         ALU_AND:  acc_nx = acc & dr;
         default:  upd    = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         dr  <= '0;
         z   <= 1'b0;
      end else begin
         if (upd) begin
            acc <= acc_nx;
            z   <= (acc_nx == '0);
         end else if (z_ld) begin
            z <= z_val;
         end
         if (mv) dr <= acc;
      end
   end

   // R4
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ALU_HOLD) |=> $stable(acc));

endmodule

// File: rtl/acc_cpu_irq_poll.sv
module acc_cpu_irq_poll #(
   parameter int NUM_IRQ = 4,
   localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] req,
   input  logic               poll,
   output logic [NUM_IRQ-1:0] ack,
   output logic [IW-1:0]      kind,
   output logic               found
);

   logic [NUM_IRQ-1:0] win;
   logic [IW-1:0]      win_idx;

   always_comb begin
      win     = '0;
      win_idx = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (req[i]) begin
            win     = '0;
            win[i]  = 1'b1;
            win_idx = IW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack   <= '0;
         kind  <= '0;
         found <= 1'b0;
      end else if (poll) begin
         ack   <= win;
         kind  <= win_idx;
         found <= |req;
      end else begin
         ack <= '0;
      end
   end

   // R8
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));
   // R8
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack) |=> (ack == '0));
   // R8
   ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack) |-> (|(ack & $past(req))));

endmodule

// File: rtl/acc_cpu_io.sv
module acc_cpu_io #(
   parameter int DW      = 4,
   parameter int AW      = 8,
   parameter int NUM_IRQ = 4,
   parameter int A_LO    = 4,
   parameter int B_LO    = 5,
   localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          svc_on,
   input  logic          found,
   input  logic [IW-1:0] kind,
   input  logic [DW-1:0] ip0,
   input  logic [DW-1:0] ip1,
   input  logic [DW-1:0] ip2,
   input  logic [DW-1:0] ip3,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] svc_addr,
   output logic          svc_we,
   output logic [DW-1:0] svc_wdata,
   output logic [DW-1:0] op0
);

   localparam logic [DW-1:0] PAGE_HI = {DW{1'b1}};
   localparam logic [AW-1:0] A_ADDR  = {PAGE_HI, DW'(A_LO)};
   localparam logic [AW-1:0] B_ADDR  = {PAGE_HI, DW'(B_LO)};

   logic [AW-1:0] d_addr;
   logic          d_en;
   logic          op0_load;

   generate
      if (NUM_IRQ == 4) begin : g_src_d
         assign d_addr = {ip2, ip3};
         assign d_en   = 1'b1;
      end else begin : g_no_src_d
         logic [2*DW-1:0] d_unused;
         assign d_unused = {ip2, ip3};
         assign d_addr   = A_ADDR;
         assign d_en     = 1'b0;
      end
   endgenerate

   always_comb begin
      svc_addr  = A_ADDR;
      svc_we    = 1'b0;
      svc_wdata = ip0;
      op0_load  = 1'b0;
      if (svc_on && found) begin
         case (kind)
            IW'(0): op0_load = 1'b1;
            IW'(1): begin
               svc_addr = B_ADDR;
               svc_we   = 1'b1;
            end
            IW'(2): begin
               svc_addr = {PAGE_HI, ip1};
               op0_load = 1'b1;
            end
            default: begin
               svc_addr = d_addr;
               op0_load = d_en;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        op0 <= '0;
      else if (op0_load) op0 <= rdata;
   end

   // R13
   op0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op0_load |=> $stable(op0));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int            DW           = 4,
   parameter int            AW           = 8,
   parameter int            NUM_IRQ      = 4,
   parameter logic [AW-1:0] HANDLER_ADDR = 8'hE0,
   parameter logic [AW-1:0] BOOT_RESUME  = 8'h01
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [AW-1:0]      mem_addr,
   input  logic [DW-1:0]      mem_rdata,
   output logic               mem_we,
   output logic [DW-1:0]      mem_wdata,
   input  logic [NUM_IRQ-1:0] irq_req,
   output logic [NUM_IRQ-1:0] irq_ack,
   input  logic [DW-1:0]      ip0,
   input  logic [DW-1:0]      ip1,
   input  logic [DW-1:0]      ip2,
   input  logic [DW-1:0]      ip3,
   output logic [DW-1:0]      op0
);

   localparam int            IW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam logic [AW-1:0] PC_ONE = AW'(1);

   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("acc_cpu: AW must be twice DW");
      end
      if (DW < OPC_W) begin : g_bad_dw
         $error("acc_cpu: DW must hold an opcode");
      end
      if (NUM_IRQ < 3 || NUM_IRQ > 4) begin : g_bad_irq
         $error("acc_cpu: NUM_IRQ must be 3 or 4");
      end
   endgenerate

   state_e            st_q;
   logic [AW-1:0]     pc_q;
   logic [OPC_W-1:0]  ir_q;
   logic [DW-1:0]     ahi_q;
   logic [DW-1:0]     alo_q;
   logic [AW-1:0]     spc_q;
   logic              sz_q;
   logic              ie_q;

   logic [DW-1:0]     acc;
   logic [DW-1:0]     dr;
   logic              z;
   alu_op_e           alu_op;
   logic              alu_mv;
   logic              z_ld;

   logic [IW-1:0]     irq_kind;
   logic              irq_found;
   logic [AW-1:0]     svc_addr;
   logic              svc_we;
   logic [DW-1:0]     svc_wdata;

   logic              take_irq;
   logic              in_exec;
   logic [AW-1:0]     opnd_addr;

   assign take_irq  = (st_q == ST_FETCH) && ie_q && (|irq_req);
   assign in_exec   = (st_q == ST_EXEC);
   assign opnd_addr = {ahi_q, alo_q};

   always_comb begin
      case (st_q)
         ST_EXEC:  mem_addr = opnd_addr;
         ST_SERVE: mem_addr = svc_addr;
         default:  mem_addr = pc_q;
      endcase
      mem_we    = (in_exec && ir_q == OPC_STORE) || (st_q == ST_SERVE && svc_we);
      mem_wdata = (st_q == ST_SERVE) ? svc_wdata : acc;
   end

   always_comb begin
      alu_op = ALU_HOLD;
      alu_mv = 1'b0;
      z_ld   = 1'b0;
      if (in_exec) begin
         case (ir_q)
            OPC_LOAD:   alu_op = ALU_LOAD;
            OPC_SUB:    alu_op = ALU_SUB;
            OPC_AND:    alu_op = ALU_AND;
            OPC_MOVE:   alu_mv = 1'b1;
            OPC_RETINT: z_ld   = 1'b1;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_FETCH;
         pc_q  <= '0;
         ir_q  <= '0;
         ahi_q <= '0;
         alo_q <= '0;
         spc_q <= BOOT_RESUME;
         sz_q  <= 1'b0;
         ie_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_FETCH: begin
               if (take_irq) begin
                  spc_q <= pc_q;
                  sz_q  <= z;
                  ie_q  <= 1'b0;
                  st_q  <= ST_POLL;
               end else begin
                  ir_q <= mem_rdata[OPC_W-1:0];
                  pc_q <= pc_q + PC_ONE;
                  st_q <= takes_addr(mem_rdata[OPC_W-1:0]) ? ST_ADRH : ST_EXEC;
               end
            end
            ST_ADRH: begin
               ahi_q <= mem_rdata;
               pc_q  <= pc_q + PC_ONE;
               st_q  <= ST_ADRL;
            end
            ST_ADRL: begin
               alo_q <= mem_rdata;
               pc_q  <= pc_q + PC_ONE;
               st_q  <= ST_EXEC;
            end
            ST_EXEC: begin
               if (ir_q == OPC_JUMPZ && z) pc_q <= opnd_addr;
               if (ir_q == OPC_RETINT) begin
                  pc_q <= spc_q;
                  ie_q <= 1'b1;
               end
               st_q <= ST_FETCH;
            end
            ST_POLL: st_q <= ST_SERVE;
            ST_SERVE: begin
               pc_q <= HANDLER_ADDR;
               st_q <= ST_FETCH;
            end
            default: st_q <= ST_FETCH;
         endcase
      end
   end

   acc_cpu_alu #(.DW(DW)) i_alu (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (alu_op),
      .mv      (alu_mv),
      .operand (mem_rdata),
      .z_ld    (z_ld),
      .z_val   (sz_q),
      .acc     (acc),
      .dr      (dr),
      .z       (z)
   );

   acc_cpu_irq_poll #(.NUM_IRQ(NUM_IRQ)) i_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (irq_req),
      .poll  (st_q == ST_POLL),
      .ack   (irq_ack),
      .kind  (irq_kind),
      .found (irq_found)
   );

   acc_cpu_io #(.DW(DW), .AW(AW), .NUM_IRQ(NUM_IRQ)) i_io (
      .clk       (clk),
      .rst_n     (rst_n),
      .svc_on    (st_q == ST_SERVE),
      .found     (irq_found),
      .kind      (irq_kind),
      .ip0       (ip0),
      .ip1       (ip1),
      .ip2       (ip2),
      .ip3       (ip3),
      .rdata     (mem_rdata),
      .svc_addr  (svc_addr),
      .svc_we    (svc_we),
      .svc_wdata (svc_wdata),
      .op0       (op0)
   );

   // R6
   ack_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> !ie_q);
   // R7
   retint_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && ir_q == OPC_RETINT) |=> ie_q);
   // R7
   entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |=> (spc_q == $past(pc_q)) && (sz_q == $past(z)));

endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] mem_addr;
   logic [3:0] mem_rdata;
   logic       mem_we;
   logic [3:0] mem_wdata;
   logic [3:0] irq_req = '0;
   logic [3:0] irq_ack;
   logic [3:0] ip0 = '0, ip1 = '0, ip2 = '0, ip3 = '0;
   logic [3:0] op0;

   logic [3:0] mem [256];
   int checks = 0;
   int failures = 0;
   int ack_cnt [4];
   logic [3:0] first_ack;
   bit done = 0;

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < 4; i++) if (irq_ack[i]) ack_cnt[i]++;
         if ((|irq_ack) && first_ack == '0) first_ack = irq_ack;
      end
   end

   acc_cpu i_acc_cpu (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .irq_req(irq_req),
      .irq_ack(irq_ack), .ip0(ip0), .ip1(ip1), .ip2(ip2), .ip3(ip3), .op0(op0)
   );

   // {opcode, ac, dr, expected ac, expected z}
   localparam logic [16:0] VEC [7] = '{
      {4'h4, 4'h7, 4'h3, 4'h4, 1'b0},
      {4'h4, 4'h5, 4'h5, 4'h0, 1'b1},
      {4'h4, 4'h2, 4'h5, 4'hD, 1'b0},
      {4'h5, 4'hC, 4'hA, 4'h8, 1'b0},
      {4'h5, 4'h5, 4'hA, 4'h0, 1'b1},
      {4'h0, 4'h0, 4'h9, 4'h0, 1'b1},
      {4'h0, 4'h6, 4'h0, 4'h6, 1'b0}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic put3(input logic [7:0] at, input logic [3:0] opc, input logic [7:0] tgt);
      mem[at] = opc;
      mem[at + 8'd1] = tgt[7:4];
      mem[at + 8'd2] = tgt[3:0];
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
   endtask

   task automatic start();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) ack_cnt[i] = 0;
      first_ack = '0;
      rst_n = 1'b1;
   endtask

   task automatic fire(input int idx, input string req);
      int n;
      @(negedge clk);
      irq_req[idx] = 1'b1;
      n = 0;
      while (!irq_ack[idx] && n < 60) begin
         @(negedge clk);
         n++;
      end
      irq_req[idx] = 1'b0;
      if (n >= 60) check(req, 8'h0, 8'h1);
      repeat (60) @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_up();
   end

   initial begin
      // R1 reset state
      clear_mem();
      put3(8'h00, 4'h1, 8'h8F);
      put3(8'h03, 4'h6, 8'h00);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 addr in reset", mem_addr, 8'h00);
      check("R1 op0/we/ack in reset", {op0, mem_we, irq_ack[2:0]}, 8'h00);
      start();
      check("R1 first fetch addr", mem_addr, 8'h00);

      // R6 masked: never enabled, request ignored
      mem[8'hF4] = 4'h5;
      irq_req[0] = 1'b1;
      repeat (60) @(negedge clk);
      irq_req[0] = 1'b0;
      check("R6 no ack while masked", 8'(ack_cnt[0]), 8'h0);
      check("R6 op0 untouched while masked", {4'h0, op0}, 8'h0);

      // Vector table: R2 R3 R4 R5
      foreach (VEC[k]) begin
         clear_mem();
         put3(8'h00, 4'h1, 8'h80);
         mem[8'h03] = 4'h3;
         put3(8'h04, 4'h1, 8'h81);
         mem[8'h07] = VEC[k][16:13];
         put3(8'h08, 4'h2, 8'h90);
         put3(8'h0B, 4'h6, 8'h20);
         put3(8'h0E, 4'h1, 8'h8C);
         put3(8'h11, 4'h2, 8'h91);
         put3(8'h14, 4'h1, 8'h8F);
         put3(8'h17, 4'h6, 8'h17);
         put3(8'h20, 4'h1, 8'h8D);
         put3(8'h23, 4'h2, 8'h91);
         put3(8'h26, 4'h1, 8'h8F);
         put3(8'h29, 4'h6, 8'h29);
         mem[8'h80] = VEC[k][8:5];
         mem[8'h81] = VEC[k][12:9];
         mem[8'h8C] = 4'h2;
         mem[8'h8D] = 4'h1;
         start();
         repeat (100) @(negedge clk);
         check("R3 R4 accumulator result via STORE", {4'h0, mem[8'h90]}, {4'h0, VEC[k][4:1]});
         check("R4 R5 zero flag via JUMPZ path", {4'h0, mem[8'h91]},
               VEC[k][0] ? 8'h01 : 8'h02);
      end

      // Interrupt program
      clear_mem();
      mem[8'h00] = 4'h7;
      put3(8'h01, 4'h1, 8'h8F);
      put3(8'h04, 4'h6, 8'h01);
      put3(8'h07, 4'h1, 8'h8C);
      put3(8'h0A, 4'h2, 8'h9F);
      put3(8'h0D, 4'h1, 8'h8F);
      put3(8'h10, 4'h6, 8'h01);
      put3(8'hE0, 4'h1, 8'h8E);
      mem[8'hE3] = 4'h7;
      mem[8'h8C] = 4'h2;
      mem[8'h8E] = 4'h3;
      mem[8'hF4] = 4'h5;
      mem[8'hF3] = 4'hC;
      mem[8'h42] = 4'h7;
      start();
      repeat (20) @(negedge clk);

      fire(0, "R9 ack A");
      check("R9 op0 from F4", {4'h0, op0}, 8'h05);
      check("R8 single ack pulse A", 8'(ack_cnt[0]), 8'h1);

      ip0 = 4'h9;
      fire(1, "R10 ack B");
      check("R10 ip0 stored at F5", {4'h0, mem[8'hF5]}, 8'h09);
      check("R13 op0 held across B", {4'h0, op0}, 8'h05);
      check("R6 re-enabled by RETINT", 8'(ack_cnt[1]), 8'h1);

      ip1 = 4'h3;
      fire(2, "R11 ack C");
      check("R11 op0 from F page", {4'h0, op0}, 8'h0C);

      ip2 = 4'h4;
      ip3 = 4'h2;
      fire(3, "R12 ack D");
      check("R12 op0 from ip2:ip3", {4'h0, op0}, 8'h07);

      // R8 priority: A and C together
      mem[8'hF4] = 4'h1;
      first_ack = '0;
      @(negedge clk);
      irq_req = 4'b0101;
      for (int n = 0; n < 60 && first_ack == '0; n++) @(negedge clk);
      check("R8 A wins over C", {4'h0, first_ack}, 8'h01);
      irq_req[0] = 1'b0;
      for (int n = 0; n < 80 && !irq_ack[2]; n++) @(negedge clk);
      irq_req[2] = 1'b0;
      repeat (60) @(negedge clk);
      check("R8 C serviced on second entry", 8'(ack_cnt[2]), 8'h2);
      check("R8 op0 after both", {4'h0, op0}, 8'h0C);
      check("R7 Z restored, no fall-through marker", {4'h0, mem[8'h9F]}, 8'h00);

      finish_up();
   end

endmodule